// File: doc/BRIEF.md
# Forty-bit accumulator arithmetic unit

This block holds two 40-bit signed accumulators and applies one arithmetic or accumulator-control operation per clock. Each accumulator is viewed as an 8-bit top byte, a 16-bit middle word and a 16-bit bottom word. Narrow operands are placed on the middle word, so adding a 16-bit value moves the accumulator in steps of 0x10000. The exception is the unsigned bottom-word add, which places its operand at bit 0. The other operand comes from the second accumulator, a 32-bit wide register, a 16-bit half register, a 40-bit product bus, or an immediate.

The surrounding sequencer drives an operation code, a destination index and the operand buses, and pulses the write strobe for one cycle. On the next clock edge the unit stores the 40-bit result in the destination accumulator and updates five status flags: carry, overflow, zero, sign and a flag that says the value no longer fits in 32 signed bits. Compare and test operations update the flags only. Instruction fetch and opcode decoding live outside the block.

Top module: `acc_arith_unit`

## Requirements
- R1: While rst_n is low, both accumulators read zero and all five flags read 0.
- R2: State changes only at a rising clock edge where wr_i was high. Only the accumulator selected by dst_i (0 or 1) is written. The other accumulator keeps its value. With wr_i low, the accumulators and flags hold.
- R3: Every result wraps to 40 bits, and bit 39 is the sign. Overflow is set when the two adder operands (after inversion for a subtraction) share a sign and the result sign differs from it.
- R4: For additions, carry is the unsigned carry out of bit 39. For subtractions and compares, carry is 1 exactly when no borrow occurs.
- R5: The 16-bit immediate (OP_ADD_IMM, OP_CMP_IMM) is sign-extended and shifted left by 16. The short immediate (OP_ADD_SIMM, OP_CMP_SIMM) uses only imm_i[7:0], sign-extended and shifted left by 16. imm_i[15:8] has no effect on the short forms.
- R6: For the half-register forms, half_i is sign-extended and shifted left by 16. For the wide forms, wide_i is sign-extended from bit 31 at bit 0. For OP_ADD_LOWU, half_i is zero-extended and added at bit 0. OP_ADD_PROD and OP_SUB_PROD use the full 40-bit prod_i.
- R7: OP_INC_MID and OP_DEC_MID add or subtract 0x10000. OP_INC and OP_DEC add or subtract 1. Carry and overflow follow R3 and R4.
- R8: The compare forms (OP_CMP_ACC computes destination minus other; OP_CMP_HALF, OP_CMP_IMM and OP_CMP_SIMM use the aligned operand) set all five flags from the 40-bit difference. They leave both accumulators unchanged.
- R9: OP_NEG stores 0 minus the accumulator. OP_ABS negates only a negative accumulator, so the most negative value 0x80_0000_0000 stays unchanged.
- R10: OP_CLR stores zero. OP_CLR_RND adds 0x7FFF and then clears bits 15:0, so a bottom word of 0x8001 rounds up and 0x8000 rounds down.
- R11: OP_NEG, OP_ABS, OP_CLR, OP_CLR_RND, OP_MOV_ACC (copy the other accumulator), OP_MOV_WIDE (load sign-extended wide_i) and OP_TST (flags from the destination, no write) all force carry and overflow to 0.
- R12: Zero is set when the 40-bit result is 0. Sign is result bit 39. The above-32 flag is set when result bits 39:31 are not all equal.
- R13: Operation codes 26 to 31 are undefined. A strobe carrying one of these codes changes neither the accumulators nor the flags. Codes 0 to 25 are listed in order by the enumeration acc_op_e in acc_arith_pkg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Operation strobe |
| op_i | input | 5 | Operation code (acc_op_e) |
| dst_i | input | 1 | Destination accumulator index |
| wide_i | input | 32 | Wide secondary register operand |
| half_i | input | 16 | Half secondary register operand |
| prod_i | input | 40 | Product operand |
| imm_i | input | 16 | Immediate operand |
| acc0_o | output | 40 | Accumulator 0 |
| acc1_o | output | 40 | Accumulator 1 |
| carry_o | output | 1 | Carry / no-borrow flag |
| ovf_o | output | 1 | Signed overflow flag |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| above_o | output | 1 | Value exceeds 32 signed bits |

## Verification
The bench goes after the operand alignment corners:
- A half operand of 0x8000 must sign-extend in the aligned form and zero-extend in the bottom-word form. A design that mixes up the two extensions stores the wrong sign.
- Only the low byte of the immediate may count in the short form. Upper-byte leakage shows up as a shifted value.

It also covers the arithmetic corners:
- Incrementing 0x7F_FFFF_FFFF must wrap to 0x80_0000_0000 with overflow set.
- A subtraction with no borrow must report carry 1. A design that uses a raw borrow flips that carry.
- The absolute value of the most negative number must stay as it is.
- The rounding clear is tested with a bottom word of 0x8000 and with 0x8001, which exposes a wrong rounding constant.

Further checks confirm that compares leave the accumulators intact, that moves clear a carry left over from an earlier operation, and that an idle strobe or an undefined code changes nothing.

// File: rtl/acc_arith_pkg.sv
`timescale 1ns/1ps
package acc_arith_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD_ACC, OP_ADD_WIDE, OP_ADD_HALF, OP_ADD_PROD, OP_ADD_LOWU,
      OP_ADD_IMM, OP_ADD_SIMM, OP_INC_MID, OP_INC,
      OP_SUB_ACC, OP_SUB_WIDE, OP_SUB_HALF, OP_SUB_PROD, OP_DEC_MID, OP_DEC,
      OP_CMP_ACC, OP_CMP_HALF, OP_CMP_IMM, OP_CMP_SIMM,
      OP_NEG, OP_ABS, OP_CLR, OP_CLR_RND, OP_MOV_ACC, OP_MOV_WIDE, OP_TST
   } acc_op_e;

   typedef struct packed {
      logic valid;     // defined operation: flags update
      logic write;     // destination accumulator is written
      logic sub;       // adder subtracts b
      logic arith;     // carry and overflow are meaningful
      logic mask_low;  // clear the bottom word after the adder
   } acc_ctl_t;

   function automatic logic op_is_cmp(logic [OP_W-1:0] op);
      return op inside {OP_CMP_ACC, OP_CMP_HALF, OP_CMP_IMM, OP_CMP_SIMM};
   endfunction

   function automatic logic op_is_plain(logic [OP_W-1:0] op);
      return op inside {OP_NEG, OP_ABS, OP_CLR, OP_CLR_RND, OP_MOV_ACC,
                        OP_MOV_WIDE, OP_TST};
   endfunction

endpackage

// File: rtl/acc_operand_sel.sv
`timescale 1ns/1ps
module acc_operand_sel
   import acc_arith_pkg::*;
#(
   parameter int ACC_W   = 40,
   parameter int HALF_W  = 16,
   parameter int WIDE_W  = 32,
   parameter int SHORT_W = 8
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [ACC_W-1:0]  dst_val_i,
   input  logic [ACC_W-1:0]  oth_val_i,
   input  logic [WIDE_W-1:0] wide_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic [ACC_W-1:0]  prod_i,
   input  logic [HALF_W-1:0] imm_i,
   output logic [ACC_W-1:0]  a_o,
   output logic [ACC_W-1:0]  b_o,
   output acc_ctl_t          ctl_o
);

   localparam int ALIGN = HALF_W;
   localparam int HPAD  = ACC_W - HALF_W - ALIGN;
   localparam int SPAD  = ACC_W - SHORT_W - ALIGN;
   localparam int WPAD  = ACC_W - WIDE_W;

   localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};
   localparam logic [ACC_W-1:0] MID_ONE = {{(ACC_W-ALIGN-1){1'b0}}, 1'b1, {ALIGN{1'b0}}};
   localparam logic [ACC_W-1:0] RND_ADD = {{(ACC_W-ALIGN+1){1'b0}}, {(ALIGN-1){1'b1}}};

   logic [ACC_W-1:0] half_al, imm_al, simm_al, wide_x, lowu_x;

   assign half_al = {{HPAD{half_i[HALF_W-1]}}, half_i, {ALIGN{1'b0}}};
   assign imm_al  = {{HPAD{imm_i[HALF_W-1]}}, imm_i, {ALIGN{1'b0}}};
   assign simm_al = {{SPAD{imm_i[SHORT_W-1]}}, imm_i[SHORT_W-1:0], {ALIGN{1'b0}}};
   assign wide_x  = {{WPAD{wide_i[WIDE_W-1]}}, wide_i};
   assign lowu_x  = {{(ACC_W-HALF_W){1'b0}}, half_i};

   always_comb begin
      a_o   = dst_val_i;
      b_o   = '0;
      ctl_o = '{valid: 1'b1, write: 1'b1, sub: 1'b0, arith: 1'b1, mask_low: 1'b0};
      case (op_i)
         OP_ADD_ACC:  b_o = oth_val_i;
         OP_ADD_WIDE: b_o = wide_x;
         OP_ADD_HALF: b_o = half_al;
         OP_ADD_PROD: b_o = prod_i;
         OP_ADD_LOWU: b_o = lowu_x;
         OP_ADD_IMM:  b_o = imm_al;
         OP_ADD_SIMM: b_o = simm_al;
         OP_INC_MID:  b_o = MID_ONE;
         OP_INC:      b_o = ONE;
         OP_SUB_ACC:  begin b_o = oth_val_i; ctl_o.sub = 1'b1; end
         OP_SUB_WIDE: begin b_o = wide_x;    ctl_o.sub = 1'b1; end
         OP_SUB_HALF: begin b_o = half_al;   ctl_o.sub = 1'b1; end
         OP_SUB_PROD: begin b_o = prod_i;    ctl_o.sub = 1'b1; end
         OP_DEC_MID:  begin b_o = MID_ONE;   ctl_o.sub = 1'b1; end
         OP_DEC:      begin b_o = ONE;       ctl_o.sub = 1'b1; end
         OP_CMP_ACC:  begin b_o = oth_val_i; ctl_o.sub = 1'b1; ctl_o.write = 1'b0; end
         OP_CMP_HALF: begin b_o = half_al;   ctl_o.sub = 1'b1; ctl_o.write = 1'b0; end
         OP_CMP_IMM:  begin b_o = imm_al;    ctl_o.sub = 1'b1; ctl_o.write = 1'b0; end
         OP_CMP_SIMM: begin b_o = simm_al;   ctl_o.sub = 1'b1; ctl_o.write = 1'b0; end
         OP_NEG: begin
            a_o = '0; b_o = dst_val_i; ctl_o.sub = 1'b1; ctl_o.arith = 1'b0;
         end
         OP_ABS: begin
            ctl_o.arith = 1'b0;
            if (dst_val_i[ACC_W-1]) begin
               a_o = '0; b_o = dst_val_i; ctl_o.sub = 1'b1;
            end
         end
         OP_CLR:      begin a_o = '0; ctl_o.arith = 1'b0; end
         OP_CLR_RND:  begin b_o = RND_ADD; ctl_o.mask_low = 1'b1; ctl_o.arith = 1'b0; end
         OP_MOV_ACC:  begin a_o = '0; b_o = oth_val_i; ctl_o.arith = 1'b0; end
         OP_MOV_WIDE: begin a_o = '0; b_o = wide_x;    ctl_o.arith = 1'b0; end
         OP_TST:      begin ctl_o.write = 1'b0; ctl_o.arith = 1'b0; end
         default:     begin ctl_o.valid = 1'b0; ctl_o.write = 1'b0; end
      endcase
   end

endmodule

// File: rtl/acc_addsub.sv
`timescale 1ns/1ps
module acc_addsub #(
   parameter int W = 40
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);

   logic [W-1:0] b_eff;
   logic [W:0]   full;

   assign b_eff   = sub_i ? ~b_i : b_i;
   assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
   assign sum_o   = full[W-1:0];
   // carry out doubles as "no borrow" when subtracting
   assign carry_o = full[W];
   assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);

endmodule

// File: rtl/acc_flag_gen.sv
`timescale 1ns/1ps
module acc_flag_gen #(
   parameter int W        = 40,
   parameter int NARROW_W = 32
) (
   input  logic [W-1:0] val_i,
   output logic         zero_o,
   output logic         sign_o,
   output logic         above_o
);

   assign zero_o = ~|val_i;
   assign sign_o = val_i[W-1];

   generate
      if (NARROW_W < W) begin : g_above
         logic [W-NARROW_W:0] top;
         assign top     = val_i[W-1:NARROW_W-1];
         assign above_o = ~((&top) | (~|top));
      end else begin : g_no_above
         assign above_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/acc_arith_unit.sv
`timescale 1ns/1ps
module acc_arith_unit
   import acc_arith_pkg::*;
#(
   parameter int ACC_W    = 40,
   parameter int HALF_W   = 16,
   parameter int WIDE_W   = 32,
   parameter int SHORT_W  = 8,
   parameter int NARROW_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [4:0]        op_i,
   input  logic              dst_i,
   input  logic [WIDE_W-1:0] wide_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic [ACC_W-1:0]  prod_i,
   input  logic [HALF_W-1:0] imm_i,
   output logic [ACC_W-1:0]  acc0_o,
   output logic [ACC_W-1:0]  acc1_o,
   output logic              carry_o,
   output logic              ovf_o,
   output logic              zero_o,
   output logic              sign_o,
   output logic              above_o
);

   localparam int NUM_ACC = 2;
   localparam logic [ACC_W-1:0] KEEP_HIGH = {{(ACC_W-HALF_W){1'b1}}, {HALF_W{1'b0}}};

   // elaboration-time parameter checks
   if (ACC_W <= 2*HALF_W)         begin : g_chk_acc  $error("ACC_W must exceed two words"); end
   if (WIDE_W >= ACC_W)           begin : g_chk_wide $error("WIDE_W must be below ACC_W"); end
   if (SHORT_W > HALF_W)          begin : g_chk_shrt $error("SHORT_W must not exceed HALF_W"); end
   if (NARROW_W > ACC_W || NARROW_W < 2) begin : g_chk_nar $error("NARROW_W out of range"); end
   if (OP_W != 5)                 begin : g_chk_op   $error("op_i width mismatch"); end

   logic [ACC_W-1:0] acc_w [NUM_ACC];
   logic [ACC_W-1:0] dst_val, oth_val, opa, opb, sum, res;
   logic             add_c, add_v, f_z, f_s, f_a;
   acc_ctl_t         ctl;

   assign dst_val = acc_w[dst_i];
   assign oth_val = acc_w[~dst_i];

   acc_operand_sel #(
      .ACC_W(ACC_W), .HALF_W(HALF_W), .WIDE_W(WIDE_W), .SHORT_W(SHORT_W)
   ) u_sel (
      .op_i(op_i), .dst_val_i(dst_val), .oth_val_i(oth_val),
      .wide_i(wide_i), .half_i(half_i), .prod_i(prod_i), .imm_i(imm_i),
      .a_o(opa), .b_o(opb), .ctl_o(ctl)
   );

   acc_addsub #(.W(ACC_W)) u_add (
      .a_i(opa), .b_i(opb), .sub_i(ctl.sub),
      .sum_o(sum), .carry_o(add_c), .ovf_o(add_v)
   );

   assign res = ctl.mask_low ? (sum & KEEP_HIGH) : sum;

   acc_flag_gen #(.W(ACC_W), .NARROW_W(NARROW_W)) u_flg (
      .val_i(res), .zero_o(f_z), .sign_o(f_s), .above_o(f_a)
   );

   generate
      for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
         logic [ACC_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_i && ctl.write && (dst_i == 1'(i)))
               q <= res;
         end
         assign acc_w[i] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_o <= 1'b0;
         ovf_o   <= 1'b0;
         zero_o  <= 1'b0;
         sign_o  <= 1'b0;
         above_o <= 1'b0;
      end else if (wr_i && ctl.valid) begin
         carry_o <= ctl.arith & add_c;
         ovf_o   <= ctl.arith & add_v;
         zero_o  <= f_z;
         sign_o  <= f_s;
         above_o <= f_a;
      end
   end

   assign acc0_o = acc_w[0];
   assign acc1_o = acc_w[1];

endmodule

// File: rtl/acc_arith_chk.sv
`timescale 1ns/1ps
module acc_arith_chk
   import acc_arith_pkg::*;
#(
   parameter int ACC_W  = 40,
   parameter int HALF_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_i,
   input logic [4:0]       op_i,
   input logic             dst_i,
   input logic [ACC_W-1:0] acc0_o,
   input logic [ACC_W-1:0] acc1_o,
   input logic             carry_o,
   input logic             ovf_o,
   input logic             zero_o,
   input logic             sign_o,
   input logic             above_o
);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(acc0_o) && $stable(acc1_o) && $stable(carry_o) &&
                $stable(ovf_o) && $stable(zero_o) && $stable(sign_o) && $stable(above_o));

   // R2
   other_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ($past(dst_i) ? $stable(acc0_o) : $stable(acc1_o)));

   // R8
   cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && op_is_cmp(op_i) |=> $stable(acc0_o) && $stable(acc1_o));

   // R11
   plain_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && op_is_plain(op_i) |=> !carry_o && !ovf_o);

   // R10
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && op_i == OP_CLR |=> zero_o && (($past(dst_i) ? acc1_o : acc0_o) == '0));

   // R10
   rnd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && op_i == OP_CLR_RND |=> (($past(dst_i) ? acc1_o[HALF_W-1:0] : acc0_o[HALF_W-1:0]) == '0));

   // R12
   sign_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && op_i <= OP_TST && !op_is_cmp(op_i) |=>
         sign_o == ($past(dst_i) ? acc1_o[ACC_W-1] : acc0_o[ACC_W-1]));

   // R13
   undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && op_i > OP_TST |=> $stable(acc0_o) && $stable(acc1_o) && $stable(carry_o) &&
                                $stable(zero_o) && $stable(above_o));

endmodule

bind acc_arith_unit acc_arith_chk #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .op_i(op_i), .dst_i(dst_i),
   .acc0_o(acc0_o), .acc1_o(acc1_o), .carry_o(carry_o), .ovf_o(ovf_o),
   .zero_o(zero_o), .sign_o(sign_o), .above_o(above_o)
);

// File: tb/tb_acc_arith_unit.sv
`timescale 1ns/1ps
module tb_acc_arith_unit;
   import acc_arith_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_i = 1'b0;
   logic [4:0]  op_i = '0;
   logic        dst_i = 1'b0;
   logic [31:0] wide_i = '0;
   logic [15:0] half_i = '0;
   logic [39:0] prod_i = '0;
   logic [15:0] imm_i = '0;
   logic [39:0] acc0_o, acc1_o;
   logic        carry_o, ovf_o, zero_o, sign_o, above_o;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   acc_arith_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .op_i(op_i), .dst_i(dst_i),
      .wide_i(wide_i), .half_i(half_i), .prod_i(prod_i), .imm_i(imm_i),
      .acc0_o(acc0_o), .acc1_o(acc1_o), .carry_o(carry_o), .ovf_o(ovf_o),
      .zero_o(zero_o), .sign_o(sign_o), .above_o(above_o)
   );

   task automatic issue(input logic [4:0] op, input logic d);
      @(negedge clk);
      op_i = op; dst_i = d; wr_i = 1'b1;
      @(negedge clk);
      wr_i = 1'b0;
   endtask

   task automatic load(input logic d, input logic [39:0] v);
      issue(OP_CLR, d);
      prod_i = v;
      issue(OP_ADD_PROD, d);
   endtask

   task automatic chk_acc(input logic d, input logic [39:0] exp, input string tag);
      logic [39:0] act;
      act = d ? acc1_o : acc0_o;
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s acc%0d actual=%h expected=%h", tag, d, act, exp);
      end
   endtask

   // flag order {carry, overflow, zero, sign, above32}
   task automatic chk_flg(input logic [4:0] exp, input string tag);
      logic [4:0] act;
      act = {carry_o, ovf_o, zero_o, sign_o, above_o};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s flags(c,v,z,s,a) actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic t_reset;
      chk_acc(0, 40'h0, "R1 reset");
      chk_acc(1, 40'h0, "R1 reset");
      chk_flg(5'b00000, "R1 reset");
   endtask

   task automatic t_wrap;
      load(0, 40'h7F_FFFF_FFFF);
      issue(OP_INC, 0);
      chk_acc(0, 40'h80_0000_0000, "R3 wrap");
      chk_flg(5'b01011, "R3 overflow");
      prod_i = 40'h80_0000_0000;
      issue(OP_ADD_PROD, 0);
      chk_acc(0, 40'h0, "R4 carry out");
      chk_flg(5'b11100, "R4 carry out");
   endtask

   task automatic t_imm;
      load(1, 40'h00_0001_0000);
      imm_i = 16'hFFFF;
      issue(OP_ADD_IMM, 1);
      chk_acc(1, 40'h0, "R5 imm16");
      chk_flg(5'b10100, "R5 imm16");
      imm_i = 16'h1280;
      issue(OP_ADD_SIMM, 1);
      chk_acc(1, 40'hFF_FF80_0000, "R5 short imm");
      chk_flg(5'b00010, "R5 short imm");
      imm_i = 16'hFF80;
      issue(OP_CMP_IMM, 1);
      chk_acc(1, 40'hFF_FF80_0000, "R8 cmp imm keeps acc");
      chk_flg(5'b10100, "R8 cmp equal");
   endtask

   task automatic t_src;
      load(0, 40'h0);
      half_i = 16'h8000;
      issue(OP_ADD_HALF, 0);
      chk_acc(0, 40'hFF_8000_0000, "R6 half sext");
      chk_flg(5'b00010, "R6 half sext");
      load(0, 40'h0);
      issue(OP_ADD_LOWU, 0);
      chk_acc(0, 40'h00_0000_8000, "R6 low unsigned");
      wide_i = 32'hFFFF_FFFF;
      issue(OP_SUB_WIDE, 0);
      chk_acc(0, 40'h00_0000_8001, "R6 wide sext");
      chk_flg(5'b00000, "R4 borrow");
   endtask

   task automatic t_step;
      load(1, 40'h12_3456_789A);
      issue(OP_INC_MID, 1);
      chk_acc(1, 40'h12_3457_789A, "R7 inc mid");
      issue(OP_INC, 1);
      chk_acc(1, 40'h12_3457_789B, "R7 inc");
      issue(OP_DEC_MID, 1);
      chk_acc(1, 40'h12_3456_789B, "R7 dec mid");
      issue(OP_DEC, 1);
      chk_acc(1, 40'h12_3456_789A, "R7 dec");
      chk_flg(5'b10001, "R7 dec no borrow");
   endtask

   task automatic t_cmp;
      load(0, 40'd5);
      load(1, 40'd7);
      issue(OP_CMP_ACC, 0);
      chk_flg(5'b00010, "R8 cmp less");
      chk_acc(0, 40'd5, "R8 cmp keeps");
      chk_acc(1, 40'd7, "R8 cmp keeps");
   endtask

   task automatic t_negabs;
      load(0, 40'd5);
      issue(OP_NEG, 0);
      chk_acc(0, 40'hFF_FFFF_FFFB, "R9 neg");
      chk_flg(5'b00010, "R9 neg");
      issue(OP_ABS, 0);
      chk_acc(0, 40'd5, "R9 abs negative");
      issue(OP_ABS, 0);
      chk_acc(0, 40'd5, "R9 abs positive");
      load(1, 40'h80_0000_0000);
      issue(OP_ABS, 1);
      chk_acc(1, 40'h80_0000_0000, "R9 abs min");
      chk_flg(5'b00011, "R9 abs min");
   endtask

   task automatic t_round;
      load(0, 40'h00_0002_8001);
      issue(OP_CLR_RND, 0);
      chk_acc(0, 40'h00_0003_0000, "R10 round up");
      load(0, 40'h00_0002_8000);
      issue(OP_CLR_RND, 0);
      chk_acc(0, 40'h00_0002_0000, "R10 round down");
      issue(OP_CLR, 0);
      chk_acc(0, 40'h0, "R10 clear");
      chk_flg(5'b00100, "R12 zero");
   endtask

   task automatic t_move;
      load(0, 40'h00_0001_0000);
      imm_i = 16'hFFFF;
      issue(OP_ADD_IMM, 0);
      chk_flg(5'b10100, "R4 carry set before move");
      wide_i = 32'h8000_0000;
      issue(OP_MOV_WIDE, 1);
      chk_acc(1, 40'hFF_8000_0000, "R11 mov wide");
      chk_flg(5'b00010, "R11 mov clears carry");
      issue(OP_MOV_ACC, 0);
      chk_acc(0, 40'hFF_8000_0000, "R11 mov acc");
      load(0, 40'h00_8000_0000);
      issue(OP_TST, 0);
      chk_acc(0, 40'h00_8000_0000, "R11 tst keeps");
      chk_flg(5'b00001, "R12 above32");
   endtask

   task automatic t_strobe;
      logic [39:0] a0, a1;
      logic [4:0]  f;
      load(0, 40'h00_0000_1234);
      load(1, 40'h00_0000_5678);
      a0 = acc0_o; a1 = acc1_o;
      f = {carry_o, ovf_o, zero_o, sign_o, above_o};
      @(negedge clk);
      op_i = OP_ADD_PROD; dst_i = 1'b0; prod_i = 40'h11; wr_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk_acc(0, a0, "R2 no strobe");
      chk_flg(f, "R2 no strobe");
      issue(5'd30, 0);
      chk_acc(0, a0, "R13 undefined code");
      chk_acc(1, a1, "R13 undefined code");
      chk_flg(f, "R13 undefined code");
      issue(OP_INC, 0);
      chk_acc(0, 40'h00_0000_1235, "R2 write dest");
      chk_acc(1, a1, "R2 other untouched");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_wrap();
      t_imm();
      t_src();
      t_step();
      t_cmp();
      t_negabs();
      t_round();
      t_move();
      t_strobe();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule